// File: doc/BRIEF.md
# J1850 Frame-End and Inter-Frame Gap Timer

This block watches the passive time on a J1850 bus line and turns it into the events that close a message. A passive stretch counted in microsecond ticks first reaches the end-of-data mark, after which an in-frame response may still begin. It then reaches the end-of-frame mark, after which the message is complete. A further separation interval completes the inter-frame gap. Any active level on the line restarts the count. The block reports the first two marks as one-cycle event pulses and the completed gap as a level.

The same timer controls when a queued byte may open a new frame. The CPU raises a request strobe when it writes the transmit data register. The block answers with a transmit-go pulse as soon as the gap allows it, or holds the request until the next gap completes. Some nodes finish the gap early because their clocks drift, so a remote frame start seen after end-of-frame is treated as a valid frame start. The timer resynchronises to that edge. A request that is already pending, or that arrives within a fixed number of block clocks after the edge, is released at once so that it joins arbitration. A later request waits for the next full gap. A break seen while transmitting ends the transmission with an abort pulse.

Top module: `jfe_gap_timer`

## Requirements
- R1: Any active level on `rx_i` clears the passive count. The passive level is set by `PASSIVE_LVL` (default 0, so a high line is active). A glitch before a mark delays that mark by a full interval counted from the glitch.
- R2: `eod_o` pulses for exactly one clock, in the cycle after the tick that brings uninterrupted passive time to `EOD_US`. It fires at most once per passive stretch.
- R3: `eof_o` pulses for exactly one clock, in the cycle after the tick that brings passive time to `EOF_US`. It fires at most once per passive stretch.
- R4: `ifs_o` is high while passive time has reached `IFS_US`, and low from reset and from the clock after any active level.
- R5: A request sampled while `ifs_o` is high and the line is passive gives a `tx_go_o` pulse on the next clock.
- R6: A request that cannot be granted is held. `tx_go_o` pulses one clock after `ifs_o` next rises.
- R7: A passive-to-active edge seen while passive time is at least `EOF_US` is a valid frame start. This includes an edge at exactly `IFS_US` and any edge after it. Such an edge releases a held request with a `tx_go_o` pulse on the next clock.
- R8: After such an edge, a request sampled 0 to `WIN_CLKS` clocks later (the edge cycle is 0) gives `tx_go_o` on the next clock. A request sampled at `WIN_CLKS`+1 clocks or later is held as in R6.
- R9: A passive-to-active edge before `EOF_US`, such as an in-frame response after end-of-data, neither releases a held request nor opens the window of R8.
- R10: The block is transmitting from its `tx_go_o` pulse until the clock in which `eod_o` is high. A `brk_i` strobe during that time gives a `tx_abort_o` pulse on the next clock and ends the transmission. A `brk_i` strobe at any other time gives no pulse.
- R11: A request sampled while transmitting produces no `tx_go_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Synchronised bus line level |
| us_tick_i | input | 1 | One-clock strobe once per microsecond |
| tx_req_i | input | 1 | Strobe for a write of the transmit data register |
| brk_i | input | 1 | Strobe for a detected break on the bus |
| eod_o | output | 1 | End-of-data event pulse |
| eof_o | output | 1 | End-of-frame event pulse |
| ifs_o | output | 1 | Inter-frame gap complete (level) |
| tx_go_o | output | 1 | Start-of-frame may be sent now (pulse) |
| tx_abort_o | output | 1 | Transmission aborted by a break (pulse) |

## Verification
The bench shrinks the microsecond marks to 20, 28 and 30 ticks and raises a tick every fourth clock. This puts every phase of the gap within a few hundred clocks, so frames, responses, early edges and held requests can all be tried in one short run. The window stays at its default of 104 clocks. Requests are placed exactly 104 and 105 clocks after an early edge, which exercises both sides of the admission boundary at the real value. Early edges are placed one tick before the full gap and exactly at it.

// File: rtl/jfe_pkg.sv
package jfe_pkg;

   typedef enum logic [1:0] {
      TXS_IDLE = 2'd0,
      TXS_WAIT = 2'd1,
      TXS_BUSY = 2'd2
   } txs_e;

   function automatic int unsigned width_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/jfe_passive_timer.sv
module jfe_passive_timer
   import jfe_pkg::*;
#(
   parameter int unsigned EOD_US      = 200,
   parameter int unsigned EOF_US      = 280,
   parameter int unsigned IFS_US      = 300,
   parameter bit          PASSIVE_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   input  logic us_tick_i,
   output logic late_edge_o,
   output logic ifs_ready_o,
   output logic eod_o,
   output logic eof_o,
   output logic ifs_o
);

   localparam int unsigned CNT_W = width_for(IFS_US);
   localparam logic [CNT_W-1:0] K_EOD = CNT_W'(EOD_US);
   localparam logic [CNT_W-1:0] K_EOF = CNT_W'(EOF_US);
   localparam logic [CNT_W-1:0] K_IFS = CNT_W'(IFS_US);

   logic             act;
   logic             act_q;
   logic             step;
   logic [CNT_W-1:0] cnt_q;

   // line polarity variant
   generate
      if (PASSIVE_LVL == 1'b0) begin : g_pas_low
         assign act = rx_i;
      end else begin : g_pas_high
         assign act = ~rx_i;
      end
   endgenerate

   assign step = !act && us_tick_i && (cnt_q != K_IFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= 1'b0;
         eod_o <= 1'b0;
         eof_o <= 1'b0;
      end else begin
         act_q <= act;
         eod_o <= step && ((cnt_q + 1'b1) == K_EOD);
         eof_o <= step && ((cnt_q + 1'b1) == K_EOF);
         if (act) begin
            cnt_q <= '0;
         end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign ifs_o       = (cnt_q == K_IFS);
   assign ifs_ready_o = ifs_o && !act;
   assign late_edge_o = act && !act_q && (cnt_q >= K_EOF);

   assert_active_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      act |=> (cnt_q == '0));
   assert_eod_at_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
      eod_o |-> (cnt_q == K_EOD));
   assert_eof_at_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
      eof_o |-> (cnt_q == K_EOF));
   assert_gap_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ifs_o && !act) |=> ifs_o);

endmodule

// File: rtl/jfe_grant_window.sv
module jfe_grant_window
   import jfe_pkg::*;
#(
   parameter int unsigned WIN_CLKS = 104
) (
   input  logic clk,
   input  logic rst_n,
   input  logic qual_i,
   output logic open_o
);

   generate
      if (WIN_CLKS == 0) begin : g_edge_only
         // only the edge cycle itself admits a request
         assign open_o = 1'b0;
      end else begin : g_counted
         localparam int unsigned WIN_W = width_for(WIN_CLKS);
         localparam logic [WIN_W-1:0] K_WIN = WIN_W'(WIN_CLKS);

         logic [WIN_W-1:0] age_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               age_q <= K_WIN;
            end else if (qual_i) begin
               age_q <= '0;
            end else if (age_q != K_WIN) begin
               age_q <= age_q + 1'b1;
            end
         end

         assign open_o = (age_q < K_WIN);

         assert_opens_after_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
            qual_i |=> open_o);
         assert_stays_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!open_o && !qual_i) |=> !open_o);
      end
   endgenerate

endmodule

// File: rtl/jfe_tx_sched.sv
module jfe_tx_sched
   import jfe_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tx_req_i,
   input  logic brk_i,
   input  logic eod_i,
   input  logic ifs_ready_i,
   input  logic qual_i,
   input  logic win_open_i,
   output logic tx_go_o,
   output logic tx_abort_o
);

   txs_e state_q, state_d;
   logic grant;
   logic go_d;
   logic abort_d;

   assign grant = ifs_ready_i || qual_i || win_open_i;

   always_comb begin
      state_d = state_q;
      go_d    = 1'b0;
      abort_d = 1'b0;
      unique case (state_q)
         TXS_IDLE: begin
            if (tx_req_i) begin
               if (grant) begin
                  go_d    = 1'b1;
                  state_d = TXS_BUSY;
               end else begin
                  state_d = TXS_WAIT;
               end
            end
         end
         TXS_WAIT: begin
            if (grant) begin
               go_d    = 1'b1;
               state_d = TXS_BUSY;
            end
         end
         TXS_BUSY: begin
            if (brk_i) begin
               abort_d = 1'b1;
               state_d = TXS_IDLE;
            end else if (eod_i) begin
               state_d = TXS_IDLE;
            end
         end
         default: state_d = TXS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= TXS_IDLE;
         tx_go_o    <= 1'b0;
         tx_abort_o <= 1'b0;
      end else begin
         state_q    <= state_d;
         tx_go_o    <= go_d;
         tx_abort_o <= abort_d;
      end
   end

   assert_abort_from_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort_o |-> $past(state_q == TXS_BUSY));
   assert_no_go_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TXS_BUSY) |=> !tx_go_o);
   assert_go_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go_o |-> $past(grant));

endmodule

// File: rtl/jfe_gap_timer.sv
module jfe_gap_timer
   import jfe_pkg::*;
#(
   parameter int unsigned EOD_US      = 200,
   parameter int unsigned EOF_US      = 280,
   parameter int unsigned IFS_US      = 300,
   parameter int unsigned WIN_CLKS    = 104,
   parameter bit          PASSIVE_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   input  logic us_tick_i,
   input  logic tx_req_i,
   input  logic brk_i,
   output logic eod_o,
   output logic eof_o,
   output logic ifs_o,
   output logic tx_go_o,
   output logic tx_abort_o
);

   generate
      if (!(EOD_US > 0 && EOD_US < EOF_US && EOF_US < IFS_US)) begin : g_bad_marks
         $error("jfe_gap_timer: marks must satisfy 0 < EOD_US < EOF_US < IFS_US");
      end
   endgenerate

   logic late_edge;
   logic ifs_ready;
   logic win_open;

   jfe_passive_timer #(
      .EOD_US     (EOD_US),
      .EOF_US     (EOF_US),
      .IFS_US     (IFS_US),
      .PASSIVE_LVL(PASSIVE_LVL)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_i       (rx_i),
      .us_tick_i  (us_tick_i),
      .late_edge_o(late_edge),
      .ifs_ready_o(ifs_ready),
      .eod_o      (eod_o),
      .eof_o      (eof_o),
      .ifs_o      (ifs_o)
   );

   jfe_grant_window #(
      .WIN_CLKS(WIN_CLKS)
   ) u_window (
      .clk   (clk),
      .rst_n (rst_n),
      .qual_i(late_edge),
      .open_o(win_open)
   );

   jfe_tx_sched u_sched (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_req_i   (tx_req_i),
      .brk_i      (brk_i),
      .eod_i      (eod_o),
      .ifs_ready_i(ifs_ready),
      .qual_i     (late_edge),
      .win_open_i (win_open),
      .tx_go_o    (tx_go_o),
      .tx_abort_o (tx_abort_o)
   );

   assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_go_o, tx_abort_o}));
   assert_late_edge_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
      late_edge |=> (win_open || WIN_CLKS == 0));

endmodule

// File: tb/sim_jfe_gap_timer.sv
`timescale 1ns/1ps
module sim_jfe_gap_timer;

   localparam int EOD = 20;
   localparam int EOF = 28;
   localparam int IFS = 30;
   localparam int WIN = 104;

   logic clk = 1'b0, rst_n = 1'b0, rx = 1'b0, tick = 1'b0, req = 1'b0, brk = 1'b0;
   logic eod, eof, ifs, go, ab;

   always #5 clk = ~clk;

   jfe_gap_timer #(.EOD_US(EOD), .EOF_US(EOF), .IFS_US(IFS), .WIN_CLKS(WIN), .PASSIVE_LVL(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .us_tick_i(tick), .tx_req_i(req), .brk_i(brk),
      .eod_o(eod), .eof_o(eof), .ifs_o(ifs), .tx_go_o(go), .tx_abort_o(ab));

   int n_chk = 0, n_fail = 0, cyc = 0;
   int obs_go = 0, obs_ab = 0, obs_eod = 0, obs_eof = 0;
   int tdiv = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // tick generator: one tick every fourth clock
   always @(negedge clk) begin
      tick <= (tdiv == 3);
      tdiv <= (tdiv + 1) % 4;
   end

   // behavioural reference model
   int m_p, m_d, m_st;
   bit m_actq, e_eod, e_eof, e_go, e_ab;
   bit a, qual, ifr, grant, n_go, n_ab, stepb, n_eod, n_eof;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_p = 0; m_d = WIN + 5; m_st = 0; m_actq = 0;
         e_eod = 0; e_eof = 0; e_go = 0; e_ab = 0;
      end else begin
         a     = (rx != 1'b0);
         qual  = a && !m_actq && (m_p >= EOF);
         ifr   = (m_p == IFS) && !a;
         grant = ifr || qual || (m_d < WIN);
         n_go = 0; n_ab = 0;
         case (m_st)
            0: if (req) begin if (grant) begin n_go = 1; m_st = 2; end else m_st = 1; end
            1: if (grant) begin n_go = 1; m_st = 2; end
            default: if (brk) begin n_ab = 1; m_st = 0; end else if (e_eod) m_st = 0;
         endcase
         stepb = !a && tick && (m_p < IFS);
         n_eod = stepb && (m_p + 1 == EOD);
         n_eof = stepb && (m_p + 1 == EOF);
         if (a) m_p = 0; else if (stepb) m_p = m_p + 1;
         if (qual) m_d = 0; else if (m_d < WIN + 5) m_d = m_d + 1;
         m_actq = a;
         e_eod = n_eod; e_eof = n_eof; e_go = n_go; e_ab = n_ab;
      end
   end

   // per-clock comparison and pulse counting
   always @(negedge clk) begin
      if (rst_n) begin
         check(eod == e_eod, "R2 eod_o vs model", eod, e_eod);
         check(eof == e_eof, "R3 eof_o vs model", eof, e_eof);
         check(ifs == (m_p == IFS), "R4 ifs_o vs model", ifs, m_p == IFS);
         check(go == e_go, "R5 tx_go_o vs model", go, e_go);
         check(ab == e_ab, "R10 tx_abort_o vs model", ab, e_ab);
         if (go) obs_go++;
         if (ab) obs_ab++;
         if (eod) obs_eod++;
         if (eof) obs_eof++;
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic wait_p(input int v);
      while (m_p != v) @(negedge clk);
   endtask
   task automatic settle();
      repeat (3) @(negedge clk);
      #1;
   endtask
   task automatic pulse_req();
      req = 1'b1; @(negedge clk); req = 1'b0;
   endtask
   task automatic pulse_brk();
      brk = 1'b1; @(negedge clk); brk = 1'b0;
   endtask
   task automatic send_frame(input int n);
      rx = 1'b1; repeat (n) @(negedge clk); rx = 1'b0;
   endtask

   initial begin
      int g0, a0, e0;
      repeat (3) @(negedge clk);
      check({eod, eof, ifs, go, ab} == 5'b0, "R4 reset state", {eod, eof, ifs, go, ab}, 0);
      rst_n = 1'b1;

      // R2 R3 R4: first gap after reset
      wait_p(IFS); settle();
      check(ifs == 1'b1, "R4 gap complete", ifs, 1);
      repeat (40) @(negedge clk); #1;
      check(obs_eod == 1, "R2 once per stretch", obs_eod, 1);
      check(obs_eof == 1, "R3 once per stretch", obs_eof, 1);

      // R5 idle request, R11 request while transmitting
      g0 = obs_go; pulse_req(); settle();
      check(obs_go == g0 + 1, "R5 immediate go at idle", obs_go, g0 + 1);
      rx = 1'b1; settle();
      check(ifs == 1'b0, "R4 cleared by active", ifs, 0);
      repeat (50) @(negedge clk);
      g0 = obs_go; pulse_req(); settle();
      check(obs_go == g0, "R11 ignored while transmitting", obs_go, g0);
      rx = 1'b0; wait_p(IFS);

      // R1 glitch restarts the count
      send_frame(120); wait_p(15);
      e0 = obs_eod;
      rx = 1'b1; @(negedge clk); rx = 1'b0;
      repeat (40) @(negedge clk); #1;
      check(obs_eod == e0, "R1 glitch delays eod", obs_eod, e0);
      wait_p(IFS); settle();
      check(obs_eod == e0 + 1, "R1 eod after full interval", obs_eod, e0 + 1);

      // R9 response edge before EOF, then R6 release at gap end
      send_frame(120); wait_p(22);
      pulse_req();
      wait_p(24); g0 = obs_go;
      rx = 1'b1; repeat (10) @(negedge clk); #1;
      check(obs_go == g0, "R9 early response no grant", obs_go, g0);
      repeat (110) @(negedge clk); rx = 1'b0;
      wait_p(IFS); settle();
      check(obs_go == g0 + 1, "R6 held request at gap end", obs_go, g0 + 1);
      send_frame(120); wait_p(IFS);

      // R7 held request released by early edge
      send_frame(120); wait_p(25); pulse_req();
      wait_p(29); g0 = obs_go;
      rx = 1'b1; settle();
      check(obs_go == g0 + 1, "R7 held request on early edge", obs_go, g0 + 1);
      repeat (120) @(negedge clk); rx = 1'b0; wait_p(IFS);

      // R8 request at the last clock of the window
      send_frame(120); wait_p(29);
      rx = 1'b1; repeat (WIN) @(negedge clk);
      g0 = obs_go; pulse_req(); settle();
      check(obs_go == g0 + 1, "R8 request at window edge", obs_go, g0 + 1);
      repeat (20) @(negedge clk); rx = 1'b0; wait_p(IFS);

      // R8 request one clock past the window, R6 deferred
      send_frame(120); wait_p(29);
      rx = 1'b1; repeat (WIN + 1) @(negedge clk);
      g0 = obs_go; pulse_req(); repeat (10) @(negedge clk); #1;
      check(obs_go == g0, "R8 late request deferred", obs_go, g0);
      rx = 1'b0; wait_p(IFS); settle();
      check(obs_go == g0 + 1, "R6 deferred request at next gap", obs_go, g0 + 1);
      send_frame(120); wait_p(IFS);

      // R7 edge exactly at the full gap opens the window
      rx = 1'b1; repeat (50) @(negedge clk);
      g0 = obs_go; pulse_req(); settle();
      check(obs_go == g0 + 1, "R7 edge at full gap", obs_go, g0 + 1);
      repeat (80) @(negedge clk); rx = 1'b0; wait_p(IFS);

      // R10 break during and outside transmission
      a0 = obs_ab; pulse_req(); rx = 1'b1; repeat (20) @(negedge clk);
      pulse_brk(); settle();
      check(obs_ab == a0 + 1, "R10 abort while transmitting", obs_ab, a0 + 1);
      repeat (20) @(negedge clk); rx = 1'b0; wait_p(IFS);
      a0 = obs_ab; pulse_brk(); settle();
      check(obs_ab == a0, "R10 no abort when idle", obs_ab, a0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule